// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O peripheral. It holds a parameterised number of 32-pin register sets. Each set has its own pin direction, an output latch, and a sampled copy of the pin inputs. The output latch is written through separate set-mask and clear-mask registers, so software never needs a read-modify-write sequence. Each pin can detect rising edges, falling edges, or both. The enables for each edge polarity are also changed through set-mask and clear-mask registers.

Pin inputs pass through a synchronizer before they are sampled or checked for edges. Every enabled edge sets a sticky status bit, which software clears by writing ones to it. The status of each 32-pin set is split into two interrupt banks: the lower 16 pins and the upper 16 pins. A single global bank-enable register decides which of these banks may drive an interrupt line. All register accesses use a simple 32-bit read/write bus whose read data is registered.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every pin is an input (pinOe all 0) and every output latch bit is 0. All edge enables, status bits and bank enables are 0, and no bank interrupt is asserted.
- R2: The direction word sits at offset +0x00 of a set. A bit of 1 makes the pin an input (its pinOe bit is 0). A bit of 0 makes it an output (its pinOe bit is 1). The word reads back as written.
- R3: Writing a mask to +0x08 sets the masked output bits to 1. Writing a mask to +0x0C clears them to 0. Mask bits of 0 leave outputs unchanged. A write to +0x04 loads the whole latch. Reads of +0x04 and +0x08 return the latch, and the latch drives pinOut.
- R4: A read of +0x10 returns the synchronized pin levels. A pin change appears there two clock edges after it occurs, so a read issued in the same cycle as the change still returns the old level.
- R5: Rising-edge enables are set with +0x14 and cleared with +0x18. Falling-edge enables are set with +0x1C and cleared with +0x20, each written as a mask. A read of a set register returns the current enables. A read of a clear register returns 0.
- R6: An enabled edge sets its bit in the status word at +0x24 on the third rising clock edge after the pin changes. This holds whether the pin is an input or an output. An edge whose polarity is not enabled sets nothing. Status bits stay set until they are cleared.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it as it was. If an enabled edge is detected in the same cycle as a clear of that bit, the bit stays set.
- R8: Bit i of the bank-enable register at 0x08 gates output bankIrq[i]. Bank 2s reflects status bits 15:0 of set s, and bank 2s+1 reflects bits 31:16. A bank line is high exactly when its enable bit is 1 and its half of the status is nonzero.
- R9: Set s starts at byte offset 0x10 + 0x28·s. Reads of any other offset, or of an address that is not word-aligned, return 0, and writes to such addresses change nothing.
- R10: Read data appears on busRdata after the clock edge that samples busRd, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| pinIn | input | 32·NUM_SETS | Pin input levels |
| pinOut | output | 32·NUM_SETS | Output latch values |
| pinOe | output | 32·NUM_SETS | Output enables (1 = driving) |
| bankIrq | output | 2·NUM_SETS | Gated bank interrupt lines |

## Verification
Some properties are checked by assertions on every cycle. These are: set-mask and clear-mask writes to the output latch take effect on exactly the masked bits, and status bits never rise without an enabled edge polarity. They also cover the sticky nature of status, write-one-to-clear when no edge arrives at the same moment, and the fact that at most one set decodes any address. Other behaviour depends on exact timing and on how banks map to pins, so only the bench scenarios can show it. This includes the three-edge latency from a pin change to a status bit, and the race in which a clear and an edge arrive together. It also includes the mapping from each of the 64 pins to its status bit and bank line, and the gating by every bank-enable pattern.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int WORD_W      = 32;
  localparam int SET_PINS    = 32;
  localparam int HALF_PINS   = 16;
  localparam int FIRST_WORD  = 4;   // byte 0x10
  localparam int STRIDE_WORD = 10;  // byte 0x28
  localparam int BANKEN_WORD = 2;   // byte 0x08

  typedef enum logic [3:0] {
    W_DIR   = 4'd0,
    W_OUT   = 4'd1,
    W_SET   = 4'd2,
    W_CLR   = 4'd3,
    W_IN    = 4'd4,
    W_SRISE = 4'd5,
    W_CRISE = 4'd6,
    W_SFALL = 4'd7,
    W_CFALL = 4'd8,
    W_STAT  = 4'd9
  } setWord_e;

  typedef struct packed {
    logic wrDir;
    logic wrOut;
    logic setOut;
    logic clrOut;
    logic setRise;
    logic clrRise;
    logic setFall;
    logic clrFall;
    logic clrStat;
  } setStrobe_t;

endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int NUM_SETS = 2,
  parameter int ADDR_W   = 8,
  localparam int NB      = 2 * NUM_SETS,
  localparam int WA_W    = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [NB-1:0]     enWdata,
  input  logic [WORD_W-1:0] setRdVal [NUM_SETS],
  output setStrobe_t        stb [NUM_SETS],
  output setWord_e          rdWord,
  output logic [NB-1:0]     bankEn,
  output logic [WORD_W-1:0] busRdata
);

  logic [WA_W-1:0]   wordAddr;
  logic              aligned;
  logic [NUM_SETS-1:0] hitVec;
  logic              isBankEn;
  logic [WORD_W-1:0] rdNext;

  assign wordAddr = busAddr[ADDR_W-1:2];
  assign aligned  = (busAddr[1:0] == 2'b00);
  assign isBankEn = aligned && (wordAddr == WA_W'(BANKEN_WORD));

  // address decode: which set, which word inside it
  always_comb begin
    logic [WA_W-1:0] rel;
    hitVec = '0;
    rdWord = W_DIR;
    rel    = '0;
    for (int s = 0; s < NUM_SETS; s++) begin
      rel = wordAddr - WA_W'(FIRST_WORD + STRIDE_WORD * s);
      if (aligned && wordAddr >= WA_W'(FIRST_WORD + STRIDE_WORD * s)
          && wordAddr < WA_W'(FIRST_WORD + STRIDE_WORD * s + STRIDE_WORD)) begin
        hitVec[s] = 1'b1;
        rdWord    = setWord_e'(rel[3:0]);
      end
    end
  end

  // per-set write strobes
  always_comb begin
    for (int s = 0; s < NUM_SETS; s++) begin
      stb[s] = '0;
      if (busWr && hitVec[s]) begin
        unique case (rdWord)
          W_DIR:   stb[s].wrDir   = 1'b1;
          W_OUT:   stb[s].wrOut   = 1'b1;
          W_SET:   stb[s].setOut  = 1'b1;
          W_CLR:   stb[s].clrOut  = 1'b1;
          W_SRISE: stb[s].setRise = 1'b1;
          W_CRISE: stb[s].clrRise = 1'b1;
          W_SFALL: stb[s].setFall = 1'b1;
          W_CFALL: stb[s].clrFall = 1'b1;
          W_STAT:  stb[s].clrStat = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdNext = '0;
    if (isBankEn) rdNext[NB-1:0] = bankEn;
    for (int s = 0; s < NUM_SETS; s++)
      if (hitVec[s]) rdNext = setRdVal[s];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankEn   <= '0;
      busRdata <= '0;
    end else begin
      if (busWr && isBankEn) bankEn <= enWdata;
      if (busRd) busRdata <= rdNext;
    end
  end

  a_r9_single_set_hit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && hitVec == '0 && !isBankEn) |=> (busRdata == '0));

  a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> $stable(busRdata));

endmodule

// File: rtl/gpio_set_dp.sv
module gpio_set_dp
  import gpio_bank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  setStrobe_t          stb,
  input  logic [WORD_W-1:0]   wdata,
  input  setWord_e            rdWord,
  input  logic [SET_PINS-1:0] pinIn,
  output logic [SET_PINS-1:0] pinOut,
  output logic [SET_PINS-1:0] pinOe,
  output logic [WORD_W-1:0]   rdVal,
  output logic [1:0]          halfPend
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SET_PINS-1:0] dirQ, outQ, riseEn, fallEn, statQ, prevQ;
  logic [SET_PINS-1:0] syncQ [SYNC_STAGES];
  logic [SET_PINS-1:0] lvl, riseHit, fallHit, edgeHit, clrMask;

  // input synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= pinIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
      prevQ <= syncQ[LAST];
    end
  end

  assign lvl     = syncQ[LAST];
  assign riseHit = lvl & ~prevQ & riseEn;
  assign fallHit = ~lvl & prevQ & fallEn;
  assign edgeHit = riseHit | fallHit;
  assign clrMask = stb.clrStat ? wdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ   <= '1;
      outQ   <= '0;
      riseEn <= '0;
      fallEn <= '0;
      statQ  <= '0;
    end else begin
      if (stb.wrDir) dirQ <= wdata;
      if (stb.wrOut)       outQ <= wdata;
      else if (stb.setOut) outQ <= outQ | wdata;
      else if (stb.clrOut) outQ <= outQ & ~wdata;
      if (stb.setRise)      riseEn <= riseEn | wdata;
      else if (stb.clrRise) riseEn <= riseEn & ~wdata;
      if (stb.setFall)      fallEn <= fallEn | wdata;
      else if (stb.clrFall) fallEn <= fallEn & ~wdata;
      // a fresh edge wins over a simultaneous clear
      statQ <= (statQ & ~clrMask) | edgeHit;
    end
  end

  always_comb begin
    unique case (rdWord)
      W_DIR:        rdVal = dirQ;
      W_OUT, W_SET: rdVal = outQ;
      W_IN:         rdVal = lvl;
      W_SRISE:      rdVal = riseEn;
      W_SFALL:      rdVal = fallEn;
      W_STAT:       rdVal = statQ;
      default:      rdVal = '0;
    endcase
  end

  assign pinOut   = outQ;
  assign pinOe    = ~dirQ;
  assign halfPend = {|statQ[SET_PINS-1:HALF_PINS], |statQ[HALF_PINS-1:0]};

  a_r3_set_mask: assert property (@(posedge clk) disable iff (!rstN)
    stb.setOut |=> ((pinOut & $past(wdata)) == $past(wdata)));

  a_r3_clr_mask: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrOut |=> ((pinOut & $past(wdata)) == '0));

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statQ & ~$past(statQ) & ~$past(riseEn | fallEn)) == '0));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !stb.clrStat |=> ((statQ & $past(statQ)) == $past(statQ)));

  a_r7_w1c: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrStat |=> ((statQ & $past(wdata) & ~$past(edgeHit)) == '0));

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_SETS    = 2,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NP         = SET_PINS * NUM_SETS,
  localparam int NB         = 2 * NUM_SETS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  input  logic [NP-1:0]     pinIn,
  output logic [NP-1:0]     pinOut,
  output logic [NP-1:0]     pinOe,
  output logic [NB-1:0]     bankIrq
);

  setStrobe_t        stb [NUM_SETS];
  setWord_e          rdWord;
  logic [NB-1:0]     bankEn;
  logic [WORD_W-1:0] setRdVal [NUM_SETS];
  logic [NB-1:0]     pend;

  gpio_bank_decode #(.NUM_SETS(NUM_SETS), .ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .enWdata(busWdata[NB-1:0]), .setRdVal(setRdVal), .stb(stb),
    .rdWord(rdWord), .bankEn(bankEn), .busRdata(busRdata)
  );

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    gpio_set_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
      .clk(clk), .rstN(rstN), .stb(stb[s]), .wdata(busWdata), .rdWord(rdWord),
      .pinIn(pinIn[s*SET_PINS +: SET_PINS]),
      .pinOut(pinOut[s*SET_PINS +: SET_PINS]),
      .pinOe(pinOe[s*SET_PINS +: SET_PINS]),
      .rdVal(setRdVal[s]), .halfPend(pend[2*s +: 2])
    );
  end

  assign bankIrq = bankEn & pend;

endmodule

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;

  localparam int NS = 2;
  localparam int NP = 64;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [NP-1:0] pinIn = '0;
  logic [NP-1:0] pinOut, pinOe;
  logic [NB-1:0] bankIrq;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  gpio_bank_ctrl u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .bankIrq(bankIrq)
  );

  function automatic logic [7:0] regA(input int s, input int w);
    return 8'(16 + 40 * s + 4 * w);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busRd = 1'b1; busAddr = a;
    @(negedge clk);
    d = busRdata;
    busRd = 1'b0;
  endtask

  task automatic setPin(input logic [NP-1:0] v);
    @(negedge clk);
    pinIn = v;
  endtask

  task automatic finish();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      finish();
    end
  end

  initial begin
    logic [31:0] d, d2;
    logic [31:0] model;
    logic [31:0] masks [4];
    masks[0] = 32'hA5A5_0F0F; masks[1] = 32'h0000_FFFF;
    masks[2] = 32'h8000_0001; masks[3] = 32'hFFFF_0000;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1 oe", 64'(pinOe), 64'h0);
    chk("R1 out", 64'(pinOut), 64'h0);
    chk("R1 irq", 64'(bankIrq), 64'h0);
    for (int s = 0; s < NS; s++) begin
      rd(regA(s, 0), d); chk("R1 dir", 64'(d), 64'hFFFF_FFFF);
      rd(regA(s, 5), d); chk("R1 rise", 64'(d), 64'h0);
      rd(regA(s, 7), d); chk("R1 fall", 64'(d), 64'h0);
      rd(regA(s, 9), d); chk("R1 stat", 64'(d), 64'h0);
    end
    rd(8'h08, d); chk("R1 bankEn", 64'(d), 64'h0);

    // R2 direction sweep
    for (int i = 0; i < 4; i++) begin
      wr(regA(0, 0), masks[i]);
      wr(regA(1, 0), ~masks[(i + 1) % 4]);
      chk("R2 oe", 64'(pinOe), {masks[(i + 1) % 4], ~masks[i]});
      rd(regA(0, 0), d); chk("R2 readback", 64'(d), 64'(masks[i]));
    end

    // R3 output latch: load, set mask, clear mask
    for (int s = 0; s < NS; s++) begin
      model = 32'h1234_5678;
      wr(regA(s, 1), model);
      for (int i = 0; i < 4; i++) begin
        wr(regA(s, 2), masks[i]); model = model | masks[i];
        rd(regA(s, 2), d); chk("R3 set", 64'(d), 64'(model));
        wr(regA(s, 3), masks[(i + 2) % 4]); model = model & ~masks[(i + 2) % 4];
        rd(regA(s, 1), d); chk("R3 clr", 64'(d), 64'(model));
        chk("R3 pinOut", 64'(pinOut[s*32 +: 32]), 64'(model));
      end
      rd(regA(s, 3), d); chk("R5 clr data reads 0", 64'(d), 64'h0);
    end

    // R4 input sampling and latency
    setPin(64'hDEAD_BEEF_0123_4567);
    rd(regA(0, 4), d); chk("R4 old level", 64'(d), 64'h0);
    repeat (3) @(posedge clk);
    rd(regA(0, 4), d); chk("R4 set0", 64'(d), 64'h0123_4567);
    rd(regA(1, 4), d); chk("R4 set1", 64'(d), 64'hDEAD_BEEF);
    setPin('0);
    repeat (4) @(posedge clk);

    // R5 enables; set0 all outputs, set1 all inputs for R6
    wr(regA(0, 0), 32'h0);
    wr(regA(1, 0), 32'hFFFF_FFFF);
    wr(regA(0, 5), 32'hFFFF_FFFF);
    wr(regA(1, 5), 32'hFFFF_FFFF);
    wr(regA(0, 6), 32'h0000_00F0);
    rd(regA(0, 5), d); chk("R5 rise clr", 64'(d), 64'hFFFF_FF0F);
    wr(regA(0, 5), 32'h0000_00F0);
    rd(regA(0, 5), d); chk("R5 rise set", 64'(d), 64'hFFFF_FFFF);
    rd(regA(0, 6), d); chk("R5 clr rise reads 0", 64'(d), 64'h0);

    // R6 rising sweep over every pin
    for (int p = 0; p < NP; p++) begin
      setPin(pinIn | (64'h1 << p));
      repeat (3) @(posedge clk);
      rd(regA(p / 32, 9), d);
      chk("R6 rise stat", 64'(d), 64'(32'h1 << (p % 32)));
      rd(regA(1 - p / 32, 9), d);
      chk("R6 other set", 64'(d), 64'h0);
      chk("R8 gated off", 64'(bankIrq), 64'h0);
      wr(regA(p / 32, 9), 32'hFFFF_FFFF);
    end

    // R6 falling sweep: only set0 has falling enabled
    wr(regA(0, 7), 32'hFFFF_FFFF);
    wr(regA(0, 6), 32'hFFFF_FFFF);
    wr(regA(1, 6), 32'hFFFF_FFFF);
    rd(regA(0, 7), d); chk("R5 fall set", 64'(d), 64'hFFFF_FFFF);
    rd(regA(0, 8), d); chk("R5 clr fall reads 0", 64'(d), 64'h0);
    for (int p = 0; p < NP; p++) begin
      setPin(pinIn & ~(64'h1 << p));
      repeat (3) @(posedge clk);
      rd(regA(p / 32, 9), d);
      chk("R6 fall stat", 64'(d), (p < 32) ? 64'(32'h1 << p) : 64'h0);
      wr(regA(p / 32, 9), 32'hFFFF_FFFF);
    end
    wr(regA(0, 8), 32'hFFFF_FFFF);

    // R8 bank gating sweep
    wr(regA(0, 5), 32'hFFFF_FFFF);
    wr(regA(1, 5), 32'hFFFF_FFFF);
    setPin((64'h1 << 3) | (64'h1 << 40) | (64'h1 << 60));
    repeat (4) @(posedge clk);
    for (int en = 0; en < 16; en++) begin
      wr(8'h08, 32'(en));
      chk("R8 irq", 64'(bankIrq), 64'(4'(en) & 4'b1101));
      rd(8'h08, d); chk("R8 bankEn read", 64'(d), 64'(en));
    end

    // R7 partial clear, zeros ignored
    wr(regA(1, 9), 32'h0000_0100);
    rd(regA(1, 9), d); chk("R7 partial clear", 64'(d), 64'h1000_0000);
    chk("R8 low half idle", 64'(bankIrq), 64'b1001);
    wr(regA(1, 9), 32'h0);
    rd(regA(1, 9), d); chk("R7 zero write", 64'(d), 64'h1000_0000);

    // R7 race: clear lands on the same edge as a new rising edge on pin 3
    wr(regA(0, 9), 32'hFFFF_FFFF);
    setPin(pinIn & ~(64'h1 << 3));
    repeat (4) @(posedge clk);
    setPin(pinIn | (64'h1 << 3));
    @(posedge clk); @(posedge clk);
    wr(regA(0, 9), 32'h0000_0008);
    rd(regA(0, 9), d); chk("R7 edge wins", 64'(d), 64'h8);
    chk("R8 irq after race", 64'(bankIrq), 64'b1001);

    // R9 unmapped and misaligned
    wr(regA(0, 0), 32'h1111_2222);
    rd(8'h00, d); chk("R9 unmapped 0x00", 64'(d), 64'h0);
    rd(8'h0C, d); chk("R9 unmapped 0x0C", 64'(d), 64'h0);
    rd(regA(2, 0), d); chk("R9 absent set", 64'(d), 64'h0);
    rd(8'h11, d); chk("R9 misaligned", 64'(d), 64'h0);
    wr(8'h11, 32'hFFFF_FFFF);
    wr(regA(2, 0), 32'h0);
    rd(regA(0, 0), d); chk("R9 writes ignored", 64'(d), 64'h1111_2222);

    // R10 read data holds
    rd(regA(1, 0), d);
    repeat (3) @(negedge clk);
    d2 = busRdata;
    chk("R10 hold", 64'(d2), 64'(d));

    finish();
  end

endmodule